// File: doc/BRIEF.md
# Cascaded Peripheral Interrupt Aggregator

This block gathers four peripheral event pulses into a secondary pending register that has its own mask. The four events are timer 1 overflow, timer 2 overflow, the waveform generator, and compare channel 5. It then folds them into two summary bits in a primary pending/mask layer. The timer overflows feed the TOVF summary. The waveform generator and compare channel 5 feed the PI summary.

Software sees four byte-wide registers on a small bus: address 0 is the secondary mask, 1 is the secondary pending, 2 is the primary mask and 3 is the primary pending. Read data follows the address combinationally. The read strobe is what causes side effects. A strobed read of the secondary pending register returns all captured events and empties that register in the same access, so software should copy the value into a shadow location before testing bits. An interrupt request leaves the block only when three conditions hold together: the summary pending bit is set, its primary mask bit is set, and a matching secondary mask bit is set.

Top module: `pirq_cascade`

## Requirements
- R1: While `rst_n` is low, all mask and pending bits clear and both interrupt requests are low. After reset, addresses 0 and 1 read 0xAA, and addresses 2 and 3 read 0x00.
- R2: In the secondary registers, bit 0 is timer 1, bit 2 is timer 2, bit 4 is the waveform generator and bit 6 is compare channel 5. Bits 1, 3, 5 and 7 always read 1, and writes to those bits have no effect. The secondary mask at address 0 is writable.
- R3: `evt_i` bit 0 is timer 1, bit 1 is timer 2, bit 2 is the waveform generator and bit 3 is compare channel 5. An event pulse sets its secondary pending bit on the next clock edge, whatever the secondary mask holds.
- R4: `rdata_o` shows the register selected by `addr_i` at all times. A cycle with `rd_en_i` high at address 1 clears every secondary pending bit at the end of that cycle. Writes to address 1 have no effect.
- R5: An event that arrives in the same cycle as a read-clear of the secondary pending register is still set after the clear.
- R6: The PI summary bit is bit 5 of address 3. It sets when a waveform generator or compare channel 5 event arrives while the matching secondary mask bit is set. An event whose secondary mask bit is clear does not set it.
- R7: The TOVF summary bit is bit 0 of address 3. It sets when a timer 1 or timer 2 overflow arrives while the matching secondary mask bit is set.
- R8: `irq_pi_o` is high exactly when all three hold: the PI summary bit is set, primary mask bit 5 (address 2) is set, and secondary mask bit 4 or 6 is set. `irq_tovf_o` follows the same rule with the TOVF summary bit, primary mask bit 0, and secondary mask bit 0 or 2.
- R9: A summary bit clears on its acknowledge input (`ack_pi_i`, `ack_tovf_i`) or on a write to address 3 with that bit at 0. Writing 1 to a summary bit leaves it unchanged.
- R10: A qualifying event that arrives in the same cycle as an acknowledge or software clear of its summary bit takes priority, and the bit stays set.
- R11: In the primary registers only bits 0 and 5 exist. All other bits read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | 4 | Single-cycle event pulses: timer 1, timer 2, waveform generator, compare 5 |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (side effects only) |
| rdata_o | output | 8 | Read data of the addressed register |
| ack_pi_i | input | 1 | Acknowledge of the PI vector |
| ack_tovf_i | input | 1 | Acknowledge of the TOVF vector |
| irq_pi_o | output | 1 | PI interrupt request |
| irq_tovf_o | output | 1 | TOVF interrupt request |

## Verification
Two pairs of functions can collide in one cycle. The first pair is the read-clear of the secondary pending register and a fresh event. The second pair is the clear of a summary bit, by acknowledge or by software write, and a fresh qualifying event. The bench drives both members of each pair on the same clock edge. It then reads back through the bus that the new event's bit survived, alongside the cleared or returned value. Each collision is judged against an expectation built from the rule that a new event beats any clear.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int DW      = 8;
  localparam int AW      = 2;
  localparam int NEV     = 4;
  localparam int NSUM    = 2;

  // event vector positions
  localparam int EV_T1   = 0;
  localparam int EV_T2   = 1;
  localparam int EV_WG   = 2;
  localparam int EV_C5   = 3;

  // event i lives at bit 2*i of the secondary byte
  localparam int SEC_STRIDE = 2;
  localparam logic [DW-1:0] SEC_RSV = 8'hAA;

  // summary index and byte position in the primary registers
  localparam int SUM_TOVF = 0;
  localparam int SUM_PI   = 1;
  localparam int PB_TOVF  = 0;
  localparam int PB_PI    = 5;

  localparam logic [AW-1:0] A_SMASK = 2'd0;
  localparam logic [AW-1:0] A_SPEND = 2'd1;
  localparam logic [AW-1:0] A_PMASK = 2'd2;
  localparam logic [AW-1:0] A_PPEND = 2'd3;

  function automatic int sum_pos(input int s);
    return (s == SUM_PI) ? PB_PI : PB_TOVF;
  endfunction
endpackage

// File: rtl/pirq_sec_bank.sv
module pirq_sec_bank
  import pirq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           mask_we_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           rd_clr_i,
  output logic [NEV-1:0] mask_o,
  output logic [NEV-1:0] pend_o,
  output logic [NEV-1:0] qual_o
);
  logic [NEV-1:0] mask_d, mask_q;
  logic [NEV-1:0] pend_d, pend_q;

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    always_comb begin
      mask_d[i] = mask_q[i];
      if (mask_we_i) mask_d[i] = wdata_i[SEC_STRIDE*i];
      // new event outranks a read-clear
      pend_d[i] = evt_i[i] | (pend_q[i] & ~rd_clr_i);
    end
    assign qual_o[i] = evt_i[i] & mask_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pirq_summary.sv
module pirq_summary (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic swclr_i,
  output logic pend_o
);
  logic pend_d, pend_q;

  always_comb begin
    pend_d = pend_q;
    if (ack_i || swclr_i) pend_d = 1'b0;
    if (set_i)            pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pirq_rdmux.sv
module pirq_rdmux
  import pirq_pkg::*;
(
  input  logic [AW-1:0]   addr_i,
  input  logic [NEV-1:0]  smask_i,
  input  logic [NEV-1:0]  spend_i,
  input  logic [NSUM-1:0] pmask_i,
  input  logic [NSUM-1:0] ppend_i,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] smask_b, spend_b, pmask_b, ppend_b;

  always_comb begin
    smask_b = SEC_RSV;
    spend_b = SEC_RSV;
    pmask_b = '0;
    ppend_b = '0;
    for (int i = 0; i < NEV; i++) begin
      smask_b[SEC_STRIDE*i] = smask_i[i];
      spend_b[SEC_STRIDE*i] = spend_i[i];
    end
    for (int s = 0; s < NSUM; s++) begin
      pmask_b[sum_pos(s)] = pmask_i[s];
      ppend_b[sum_pos(s)] = ppend_i[s];
    end
    unique case (addr_i)
      A_SMASK: rdata_o = smask_b;
      A_SPEND: rdata_o = spend_b;
      A_PMASK: rdata_o = pmask_b;
      default: rdata_o = ppend_b;
    endcase
  end
endmodule

// File: rtl/pirq_cascade.sv
module pirq_cascade
  import pirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    evt_i,
  input  logic [1:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic [7:0]    rdata_o,
  input  logic          ack_pi_i,
  input  logic          ack_tovf_i,
  output logic          irq_pi_o,
  output logic          irq_tovf_o
);
  logic [NEV-1:0]  smask_q, spend_q, qual;
  logic [NSUM-1:0] pmask_d, pmask_q, ppend_q;
  logic [NSUM-1:0] sum_set, sum_ack, sum_swclr, sum_smask;
  logic            smask_we, spend_clr, pmask_we, ppend_we;

  assign smask_we  = wr_en_i && (addr_i == A_SMASK);
  assign spend_clr = rd_en_i && (addr_i == A_SPEND);
  assign pmask_we  = wr_en_i && (addr_i == A_PMASK);
  assign ppend_we  = wr_en_i && (addr_i == A_PPEND);

  pirq_sec_bank u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .mask_we_i (smask_we),
    .wdata_i   (wdata_i),
    .rd_clr_i  (spend_clr),
    .mask_o    (smask_q),
    .pend_o    (spend_q),
    .qual_o    (qual)
  );

  assign sum_set[SUM_TOVF]   = qual[EV_T1] | qual[EV_T2];
  assign sum_set[SUM_PI]     = qual[EV_WG] | qual[EV_C5];
  assign sum_smask[SUM_TOVF] = smask_q[EV_T1] | smask_q[EV_T2];
  assign sum_smask[SUM_PI]   = smask_q[EV_WG] | smask_q[EV_C5];
  assign sum_ack[SUM_TOVF]   = ack_tovf_i;
  assign sum_ack[SUM_PI]     = ack_pi_i;

  for (genvar s = 0; s < NSUM; s++) begin : g_sum
    assign sum_swclr[s] = ppend_we && !wdata_i[sum_pos(s)];
    always_comb begin
      pmask_d[s] = pmask_q[s];
      if (pmask_we) pmask_d[s] = wdata_i[sum_pos(s)];
    end
    pirq_summary u_sum (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (sum_set[s]),
      .ack_i   (sum_ack[s]),
      .swclr_i (sum_swclr[s]),
      .pend_o  (ppend_q[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pmask_q <= '0;
    else        pmask_q <= pmask_d;
  end

  pirq_rdmux u_rd (
    .addr_i  (addr_i),
    .smask_i (smask_q),
    .spend_i (spend_q),
    .pmask_i (pmask_q),
    .ppend_i (ppend_q),
    .rdata_o (rdata_o)
  );

  assign irq_tovf_o = ppend_q[SUM_TOVF] & pmask_q[SUM_TOVF] & sum_smask[SUM_TOVF];
  assign irq_pi_o   = ppend_q[SUM_PI]   & pmask_q[SUM_PI]   & sum_smask[SUM_PI];
endmodule

// File: rtl/pirq_cascade_chk.sv
module pirq_cascade_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] evt_i,
  input logic [1:0] addr_i,
  input logic       rd_en_i,
  input logic       ack_pi_i,
  input logic [7:0] rdata_o,
  input logic       irq_pi_o,
  input logic       irq_tovf_o,
  input logic [3:0] smask_q,
  input logic [3:0] spend_q,
  input logic [1:0] pmask_q,
  input logic [1:0] ppend_q
);
  // R2: reserved bits of the secondary registers always read 1
  a_r2_rsv_read_one: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 2'd0 || addr_i == 2'd1) |-> ((rdata_o & 8'hAA) == 8'hAA));

  // R4: a strobed read with no new events empties the secondary pending
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == 2'd1 && evt_i == 4'd0) |=> (spend_q == 4'd0));

  // R5: an event on the read-clear cycle survives
  a_r5_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == 2'd1 && evt_i[0]) |=> spend_q[0]);

  // R3: any event is captured, masked or not
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[2] |=> spend_q[2]);

  // R8: a PI request needs summary pending, primary and secondary masks
  a_r8_irq_pi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pi_o |-> (ppend_q[1] && pmask_q[1] && (smask_q[2] || smask_q[3])));

  a_r8_irq_tovf_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tovf_o |-> (ppend_q[0] && pmask_q[0] && (smask_q[0] || smask_q[1])));

  // R10: qualifying event beats a simultaneous acknowledge
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pi_i && evt_i[3] && smask_q[3]) |=> ppend_q[1]);
endmodule

bind pirq_cascade pirq_cascade_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .addr_i     (addr_i),
  .rd_en_i    (rd_en_i),
  .ack_pi_i   (ack_pi_i),
  .rdata_o    (rdata_o),
  .irq_pi_o   (irq_pi_o),
  .irq_tovf_o (irq_tovf_o),
  .smask_q    (smask_q),
  .spend_q    (spend_q),
  .pmask_q    (pmask_q),
  .ppend_q    (ppend_q)
);

// File: tb/pirq_cascade_tb.sv
`timescale 1ns/1ps
module pirq_cascade_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] evt_i = '0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic       ack_pi_i = 1'b0;
  logic       ack_tovf_i = 1'b0;
  logic       irq_pi_o, irq_tovf_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pirq_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .rdata_o(rdata_o), .ack_pi_i(ack_pi_i), .ack_tovf_i(ack_tovf_i),
    .irq_pi_o(irq_pi_o), .irq_tovf_o(irq_tovf_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; one rising edge per call
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; #1 d = rdata_o;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1; #1 d = rdata_o;
    @(negedge clk); rd_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] e);
    evt_i = e; @(negedge clk); evt_i = '0;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    wr(2'd3, 8'h00); rd(2'd1, d); wr(2'd0, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(2'd0, d); check("R1 smask", d, 8'hAA);
    peek(2'd1, d); check("R1 spend", d, 8'hAA);
    peek(2'd2, d); check("R1 pmask", d, 8'h00);
    peek(2'd3, d); check("R1 ppend", d, 8'h00);
    check("R1 irqs", {6'd0, irq_pi_o, irq_tovf_o}, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(2'd0, 8'hFF); peek(2'd0, d); check("R2 mask all", d, 8'hFF);
    wr(2'd0, 8'h00); peek(2'd0, d); check("R2 rsv stays 1", d, 8'hAA);
    wr(2'd0, 8'h10); peek(2'd0, d); check("R2 wg mask bit4", d, 8'hBA);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_capture_clear();
    logic [7:0] d;
    pulse(4'b0001); peek(2'd1, d); check("R3 t1 bit0", d, 8'hAB);
    pulse(4'b1110); peek(2'd1, d); check("R3 all unmasked", d, 8'hFF);
    peek(2'd3, d); check("R6 unmasked no summary", d, 8'h00);
    rd(2'd1, d); check("R4 read value", d, 8'hFF);
    peek(2'd1, d); check("R4 cleared", d, 8'hAA);
    wr(2'd1, 8'h55); peek(2'd1, d); check("R4 write ignored", d, 8'hAA);
  endtask

  task automatic t_race_clear();
    logic [7:0] d;
    pulse(4'b0001);
    evt_i = 4'b0010;
    rd(2'd1, d); evt_i = '0;
    check("R5 read sees old", d, 8'hAB);
    peek(2'd1, d); check("R5 new event survives", d, 8'hAE);
    rd(2'd1, d);
  endtask

  task automatic t_pi();
    logic [7:0] d;
    wr(2'd0, 8'h10); wr(2'd2, 8'h20);
    pulse(4'b0100);
    peek(2'd3, d); check("R6 pi set", d, 8'h20);
    check("R8 irq_pi on", {7'd0, irq_pi_o}, 8'h01);
    wr(2'd2, 8'h00); check("R8 primary mask gates", {7'd0, irq_pi_o}, 8'h00);
    wr(2'd2, 8'h20); wr(2'd0, 8'h00);
    check("R8 secondary mask gates", {7'd0, irq_pi_o}, 8'h00);
    ack_pi_i = 1'b1; @(negedge clk); ack_pi_i = 1'b0;
    peek(2'd3, d); check("R9 ack clears pi", d, 8'h00);
    clear_all();
  endtask

  task automatic t_tovf();
    logic [7:0] d;
    wr(2'd0, 8'h04);
    pulse(4'b0010);
    peek(2'd3, d); check("R7 tovf set", d, 8'h01);
    check("R8 tovf pri mask off", {7'd0, irq_tovf_o}, 8'h00);
    wr(2'd2, 8'h01); check("R8 irq_tovf on", {7'd0, irq_tovf_o}, 8'h01);
    wr(2'd3, 8'h21); peek(2'd3, d); check("R9 write one keeps", d, 8'h01);
    wr(2'd3, 8'h00); peek(2'd3, d); check("R9 write zero clears", d, 8'h00);
    pulse(4'b0001); peek(2'd3, d); check("R7 t1 masked off", d, 8'h00);
    clear_all();
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(2'd0, 8'h41);
    pulse(4'b1000); peek(2'd3, d); check("R6 c5 sets pi", d, 8'h20);
    ack_pi_i = 1'b1; evt_i = 4'b1000;
    @(negedge clk); ack_pi_i = 1'b0; evt_i = '0;
    peek(2'd3, d); check("R10 event beats ack", d, 8'h20);
    evt_i = 4'b0001; wr(2'd3, 8'h00); evt_i = '0;
    peek(2'd3, d); check("R10 event beats sw clear", d, 8'h01);
    clear_all();
  endtask

  task automatic t_primary_rsv();
    logic [7:0] d;
    wr(2'd2, 8'hFF); peek(2'd2, d); check("R11 pmask impl bits", d, 8'h21);
    wr(2'd3, 8'hFF); peek(2'd3, d); check("R11 ppend no set", d, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_capture_clear();
    t_race_clear();
    t_pi();
    t_tovf();
    t_priority();
    t_primary_rsv();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule